// File: doc/BRIEF.md
# Serial EEPROM Target on I2C

This block behaves as a small byte-addressed serial memory on a two-wire I2C bus. It samples the bus clock and data lines on the system clock and finds start and stop conditions. It answers one fixed 7-bit device address. It pulls the data line low through an open-drain enable and never drives it high. The storage is a register array inside the block.

A master writes one byte by sending the device address with the write flag, a word address and one data byte. The master then issues a stop, which commits the byte. After the commit, a self-timed write window runs for a parameterised number of system clocks. During that window every address byte goes unacknowledged, so the master can poll until it gets an ACK. Reads start at a persistent word-address counter. The counter holds the last address accessed plus one and wraps to zero. Each master ACK moves the read on to the next byte.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset `sda_oe_o` is low, the word-address counter is 0 and every memory byte reads 0x00.
- R2: The first byte after a start is the device address. Bits 7..1 must equal `DEV_ADDR` (default 7'b1010000), and bit 0 = 1 selects a read while bit 0 = 0 selects a write. A matching address is acknowledged.
- R3: An address byte whose upper seven bits do not match is not acknowledged. The block then drives nothing on later clocks until the next start.
- R4: Bytes are transferred 8 bits at a time, MSB first. The block pulls SDA low during the ninth SCL clock of every byte it acknowledges.
- R5: A byte write consists of the write-flagged address, a word address and a data byte, each acknowledged. Memory changes only when a stop follows the data byte. A start in place of that stop discards the byte and starts no write window.
- R6: A committed write starts a busy window of `WRITE_CYCLES` system clocks. During the window no address byte is acknowledged. Once the window ends, an address byte is acknowledged again.
- R7: The word-address counter holds the last accessed address plus one. It wraps from the last byte (`MEM_DEPTH`-1) to address 0.
- R8: A read-flagged address starts shifting out the byte at the counter. A master NACK (SDA high on the ninth clock) ends the output, and later clocks read 0xFF until the next start.
- R9: A master ACK on the ninth clock of a read byte shifts out the next byte in address order.
- R10: SDA is only ever pulled low, and `sda_oe_o` changes only while SCL is low.
- R11: A start in the middle of any phase aborts it and begins a new address phase. An acknowledged word address loads the counter even when no data byte follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (resolved bus) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with `WRITE_CYCLES` = 400 and keeps the default depth of 256. A single address byte with its start takes fewer system clocks than the write window, so a poll placed right after a commit falls inside the busy window and must be refused. A later poll after the window has expired must be acknowledged. With the full 8-bit depth, the word address 0xFF can be reached from the bus, so the wrap of a sequential read from 0xFF to 0x00 is exercised directly.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_WAIT_STOP, ST_TX, ST_MACK
  } st_e;

  typedef enum logic [1:0] {
    PH_DEV, PH_WADDR, PH_WDATA
  } ph_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer #(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic busy_o
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt <= '0;
    else if (kick_i)       cnt <= CW'(WRITE_CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eeprom_i2c_pkg::*;
#(
  parameter int         MEM_DEPTH    = 256,
  parameter int         WRITE_CYCLES = 1000,
  parameter logic [6:0] DEV_ADDR     = 7'b1010000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int ADDR_W = $clog2(MEM_DEPTH);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, commit, waddr_ld;

  st_e              state;
  ph_e              phase;
  logic [3:0]       bit_cnt;
  logic [7:0]       rx_sh, tx_sh, wr_data;
  logic             rw_q, mack_q, oe_q;
  logic [ADDR_W-1:0] wr_ptr, word_cnt;
  logic [7:0]       mem [MEM_DEPTH];

  i2c_line_sync #(.STAGES(2)) sync_i (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  assign commit = stop_ev && (state == ST_WAIT_STOP);

  eeprom_busy_timer #(.WRITE_CYCLES(WRITE_CYCLES)) timer_i (
    .clk_i, .rst_ni, .kick_i(commit), .busy_o(busy)
  );

  // Byte decision at the fall that closes the 8th data clock
  logic rx_done, dev_match;
  assign rx_done   = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
  assign dev_match = (rx_sh[7:1] == DEV_ADDR) && !busy;
  assign waddr_ld  = rx_done && (phase == PH_WADDR) && !start_ev && !stop_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      phase    <= PH_DEV;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      wr_data  <= '0;
      wr_ptr   <= '0;
      word_cnt <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start_ev) begin
      state   <= ST_RX;
      phase   <= PH_DEV;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (stop_ev) begin
      if (commit) word_cnt <= ADDR_W'(wr_ptr + 1'b1);
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (rx_done) begin
            bit_cnt <= '0;
            unique case (phase)
              PH_DEV: begin
                if (dev_match) begin
                  rw_q  <= rx_sh[0];
                  oe_q  <= 1'b1;
                  state <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
              PH_WADDR: begin
                wr_ptr   <= rx_sh[ADDR_W-1:0];
                word_cnt <= rx_sh[ADDR_W-1:0];
                oe_q     <= 1'b1;
                state    <= ST_ACK;
              end
              default: begin
                wr_data <= rx_sh;
                oe_q    <= 1'b1;
                state   <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_q <= 1'b0;
            unique case (phase)
              PH_DEV: begin
                if (rw_q) begin
                  tx_sh    <= mem[word_cnt];
                  oe_q     <= ~mem[word_cnt][7];
                  word_cnt <= ADDR_W'(word_cnt + 1'b1);
                  bit_cnt  <= '0;
                  state    <= ST_TX;
                end else begin
                  phase <= PH_WADDR;
                  state <= ST_RX;
                end
              end
              PH_WADDR: begin
                phase <= PH_WDATA;
                state <= ST_RX;
              end
              default: state <= ST_WAIT_STOP;
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              oe_q    <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_MACK;
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              oe_q    <= ~tx_sh[6];
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              tx_sh    <= mem[word_cnt];
              oe_q     <= ~mem[word_cnt][7];
              word_cnt <= ADDR_W'(word_cnt + 1'b1);
              state    <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;  // ST_IDLE, ST_WAIT_STOP: wait for start or stop
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[wr_ptr] <= wr_data;
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eeprom_i2c_target_chk.sv
module eeprom_i2c_target_chk
  import eeprom_i2c_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000,
  parameter int ADDR_W       = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              sda_oe_o,
  input logic              busy,
  input logic              commit,
  input logic              waddr_ld,
  input st_e               state,
  input logic [ADDR_W-1:0] word_cnt
);
  int busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);  // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe_o);  // R3

  AST_ACK_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ACK) |-> sda_oe_o);  // R4

  AST_BUSY_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);  // R6

  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (busy_len == WRITE_CYCLES));  // R6

  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy);  // R5

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($changed(word_cnt) && !$past(waddr_ld) && !$past(commit))
      |-> (word_cnt == ADDR_W'($past(word_cnt) + 1'b1)));  // R7
endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk #(
  .WRITE_CYCLES(WRITE_CYCLES),
  .ADDR_W(ADDR_W)
) chk_i (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .scl_s(scl_s),
  .sda_oe_o(sda_oe_o),
  .busy(busy),
  .commit(commit),
  .waddr_ld(waddr_ld),
  .state(state),
  .word_cnt(word_cnt)
);

// File: tb/eeprom_i2c_target_tb_top.sv
`timescale 1ns/1ps
module eeprom_i2c_target_tb_top;
  localparam int WCYC = 400;
  localparam int Q    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  int n_chk  = 0;
  int n_fail = 0;
  int oe_viol = 0;
  logic oe_prev = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  eeprom_i2c_target #(.MEM_DEPTH(256), .WRITE_CYCLES(WCYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  // R10 monitor: enable may change only while SCL is low
  always @(negedge clk) begin
    if (rst_n && scl_m && (sda_oe !== oe_prev)) oe_viol++;
    oe_prev <= sda_oe;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked, output logic drove);
    drove = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(Q/2);
      if (sda_oe) drove = 1'b1;
      wq(Q - Q/2); scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(Q/2);
    acked = ~sda_line;
    wq(Q - Q/2); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(Q/2);
      b[i] = sda_line;
      wq(Q - Q/2); scl_m = 1'b0;
    end
    sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic write_mem(input logic [7:0] a, input logic [7:0] d, input string tag);
    logic ak0, ak1, ak2, dr;
    bus_start();
    send_byte(8'hA0, ak0, dr);
    send_byte(a, ak1, dr);
    send_byte(d, ak2, dr);
    bus_stop();
    check(ak0 && ak1 && ak2, tag, {ak0, ak1, ak2}, 3'b111);
    wq(WCYC + 20);
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
  endtask

  task automatic t_write_and_poll();
    logic ak0, ak1, ak2, dr;
    bus_start();
    send_byte(8'hA0, ak0, dr);
    check(ak0, "R2 write address ACK", ak0, 1);
    send_byte(8'h10, ak1, dr);
    send_byte(8'hA5, ak2, dr);
    check(ak1 && ak2, "R4 word/data ACK", {ak1, ak2}, 2'b11);
    bus_stop();
    bus_start();
    send_byte(8'hA0, ak0, dr);
    check(!ak0, "R6 poll during busy NACK", ak0, 0);
    bus_stop();
    wq(WCYC);
    bus_start();
    send_byte(8'hA0, ak0, dr);
    check(ak0, "R6 poll after busy ACK", ak0, 1);
    bus_stop();
  endtask

  task automatic t_seq_read();
    logic ak, dr;
    logic [7:0] b;
    write_mem(8'h11, 8'h3C, "R5 setup write 0x11");
    bus_start();
    send_byte(8'hA0, ak, dr);
    send_byte(8'h10, ak, dr);
    bus_start();
    send_byte(8'hA1, ak, dr);
    check(ak, "R11 repeated start read ACK", ak, 1);
    recv_byte(1'b1, b);
    check(b == 8'hA5, "R11 address-only write sets counter", b, 8'hA5);
    recv_byte(1'b0, b);
    check(b == 8'h3C, "R9 sequential next byte", b, 8'h3C);
    bus_stop();
    bus_start();
    send_byte(8'hA1, ak, dr);
    recv_byte(1'b0, b);
    bus_stop();
    check(b == 8'h00, "R7 current read at last+1 (0x12)", b, 8'h00);
    bus_start();
    send_byte(8'hA1, ak, dr);
    recv_byte(1'b0, b);
    bus_stop();
    check(b == 8'h00 && ak, "R8 current read 0x13", b, 8'h00);
  endtask

  task automatic t_no_commit();
    logic ak, dr;
    logic [7:0] b;
    bus_start();
    send_byte(8'hA0, ak, dr);
    send_byte(8'h20, ak, dr);
    send_byte(8'h99, ak, dr);
    bus_start();
    send_byte(8'hA1, ak, dr);
    check(ak, "R5 no busy after aborted write", ak, 1);
    recv_byte(1'b0, b);
    bus_stop();
    check(b == 8'h00, "R5 data not committed without stop", b, 8'h00);
  endtask

  task automatic t_wrap();
    logic ak, dr;
    logic [7:0] b;
    write_mem(8'h00, 8'h5A, "R5 setup write 0x00");
    write_mem(8'hFF, 8'h77, "R5 setup write 0xFF");
    bus_start();
    send_byte(8'hA1, ak, dr);
    recv_byte(1'b0, b);
    bus_stop();
    check(b == 8'h5A, "R7 counter wrapped after write to 0xFF", b, 8'h5A);
    bus_start();
    send_byte(8'hA0, ak, dr);
    send_byte(8'hFF, ak, dr);
    bus_start();
    send_byte(8'hA1, ak, dr);
    recv_byte(1'b1, b);
    check(b == 8'h77, "R9 read at 0xFF", b, 8'h77);
    recv_byte(1'b0, b);
    bus_stop();
    check(b == 8'h5A, "R7 sequential wrap to 0x00", b, 8'h5A);
  endtask

  task automatic t_bad_addr();
    logic ak, dr;
    bus_start();
    send_byte(8'hA2, ak, dr);
    check(!ak, "R3 mismatched address NACK", ak, 0);
    send_byte(8'h00, ak, dr);
    check(!ak && !dr, "R3 bus ignored after mismatch", {ak, dr}, 0);
    bus_stop();
    bus_start();
    send_byte(8'hB1, ak, dr);
    check(!ak, "R2 upper nibble mismatch NACK", ak, 0);
    bus_stop();
  endtask

  task automatic t_nack_ends();
    logic ak, dr;
    logic [7:0] b;
    bus_start();
    send_byte(8'hA0, ak, dr);
    send_byte(8'h10, ak, dr);
    bus_start();
    send_byte(8'hA1, ak, dr);
    recv_byte(1'b0, b);
    check(b == 8'hA5, "R8 first byte before NACK", b, 8'hA5);
    recv_byte(1'b0, b);
    bus_stop();
    check(b == 8'hFF, "R8 no output after master NACK", b, 8'hFF);
  endtask

  task automatic t_mid_byte_start();
    logic ak, dr;
    logic [7:0] b;
    bus_start();
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0;
    end
    bus_start();
    send_byte(8'hA0, ak, dr);
    check(ak, "R11 start mid-byte restarts address phase", ak, 1);
    send_byte(8'hFF, ak, dr);
    bus_start();
    send_byte(8'hA1, ak, dr);
    recv_byte(1'b0, b);
    bus_stop();
    check(b == 8'h77, "R11 read after mid-byte restart", b, 8'h77);
  endtask

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_write_and_poll();
    t_seq_read();
    t_no_commit();
    t_wrap();
    t_bad_addr();
    t_nack_ends();
    t_mid_byte_start();
    check(oe_viol == 0, "R10 enable stable while SCL high", oe_viol, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule